// File: doc/BRIEF.md
# Quad Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs. Software sets them up through a single-cycle register port made of an address, a write strobe, write data and combinational read data. Each channel has three registers: control, duty and period. The control register holds a channel enable and a 14-bit prescale value. The prescaler divides the input clock into ticks. Each tick advances the channel's period counter. The output is high for the first `duty` ticks of every period of `period` ticks. Because the prescaler stretches both counts by the same factor, one period lasts (prescale+1)×period clocks and the high phase lasts (prescale+1)×duty clocks.

A single master enable sits above all channels. A channel runs only when both the master enable and its own enable are set. Duty, period and prescale writes land in shadow registers, so software can change them while a channel runs without tearing a period. The running values take the shadow contents at the end of each period, or at once when a channel starts. Every register reads back what was last written, so software can toggle an enable with a read-modify-write.

Top module: `pwm_quad`

## Requirements
- R1: Each channel owns a 16-byte bank at byte address ch×0x10. Offset 0x0 is control, with the enable in bit 0 and the prescale in bits 15:2. Offset 0x4 is duty, a 16-bit value in bits 15:0. Offset 0x8 is period, a 16-bit value in bits 15:0. Reads return the last written values, and every other bit reads zero.
- R2: The master enable is bit 0 at byte address 0x3C and reads back. While it is clear, every output is low.
- R3: A channel whose own enable is clear drives its output low, whatever the master enable is.
- R4: A running channel repeats a period of (prescale+1)×max(period,1) clocks. In each period the output is high for the first (prescale+1)×duty clocks and low for the rest.
- R5: When duty ≥ period (with duty ≠ 0) the output stays high for the whole period. When duty = 0 it stays low.
- R6: Duty, period and prescale writes to a running channel take effect only at the next period boundary. When a channel starts, it loads these values at once, and its first period begins on the clock edge after the write that starts it.
- R7: Stopping a channel, either through its own enable or the master enable, clears its prescaler and period counter. A restart therefore begins a fresh period.
- R8: Reads of an unmapped or unaligned address return zero, and writes to such an address change no register.
- R9: After reset, all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the PWM count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pwm_out | output | 4 | One PWM output per channel, active high |

## Verification
Some properties are checked on every clock cycle. A stopped channel's counters are cleared on the following edge. A running channel's counters stay within the active period and prescale. The running duty, period and prescale stay fixed everywhere except at a period start. Full-duty channels stay high. A master write lands in the master bit. Other behaviour needs the bench's scenarios. These cover the exact clock-by-clock waveform for several duty, period and prescale settings, and the point at which a mid-period duty change first appears. They also cover register read-back and masking, unmapped and misaligned accesses, and the restart from a fresh period after the master enable is cleared and set again.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // register select field, taken from byte address bits 3:2
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PER    = 2'd2,
    SEL_MASTER = 2'd3
  } reg_sel_e;

  localparam int BANK_LSB = 4;  // 16-byte stride between channel banks
  localparam int SEL_LSB  = 2;
  localparam int PRE_LSB  = 2;  // prescale field position in control
  localparam int EN_BIT   = 0;

endpackage

// File: rtl/pwm_quad_rst_sync.sv
module pwm_quad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic                           master_en,
  output logic [NUM_CH-1:0]              ch_en,
  output logic [NUM_CH-1:0][PRE_W-1:0]   ch_pre,
  output logic [NUM_CH-1:0][CNT_W-1:0]   ch_duty,
  output logic [NUM_CH-1:0][CNT_W-1:0]   ch_per
);

  localparam int CH_W      = $clog2(NUM_CH);
  localparam int MASTER_CH = NUM_CH - 1;

  logic            aligned;
  logic            in_range;
  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;
  logic            master_hit;
  logic            master_d;
  logic            unused_wdata;

  always_comb begin
    aligned  = (addr[SEL_LSB-1:0] == '0);
    in_range = ((addr >> (BANK_LSB + CH_W)) == '0);
    ch_idx   = addr[BANK_LSB +: CH_W];
    sel      = reg_sel_e'(addr[SEL_LSB +: 2]);
  end

  assign unused_wdata = ^wdata;

  // master enable
  always_comb begin
    master_hit = we && aligned && in_range && (sel == SEL_MASTER)
                 && (ch_idx == CH_W'(MASTER_CH));
    master_d   = master_hit ? wdata[EN_BIT] : master_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_en <= 1'b0;
    else        master_en <= master_d;
  end

  // per-channel register banks
  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    logic             bank_hit;
    logic             ctrl_we;
    logic             duty_we;
    logic             per_we;
    logic             en_d;
    logic [PRE_W-1:0] pre_d;
    logic [CNT_W-1:0] duty_d;
    logic [CNT_W-1:0] per_d;

    always_comb begin
      bank_hit = we && aligned && in_range && (ch_idx == CH_W'(c));
      ctrl_we  = bank_hit && (sel == SEL_CTRL);
      duty_we  = bank_hit && (sel == SEL_DUTY);
      per_we   = bank_hit && (sel == SEL_PER);
      en_d     = ctrl_we ? wdata[EN_BIT]              : ch_en[c];
      pre_d    = ctrl_we ? wdata[PRE_LSB +: PRE_W]    : ch_pre[c];
      duty_d   = duty_we ? wdata[CNT_W-1:0]           : ch_duty[c];
      per_d    = per_we  ? wdata[CNT_W-1:0]           : ch_per[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_en[c]   <= 1'b0;
        ch_pre[c]  <= '0;
        ch_duty[c] <= '0;
        ch_per[c]  <= '0;
      end else begin
        ch_en[c]   <= en_d;
        ch_pre[c]  <= pre_d;
        ch_duty[c] <= duty_d;
        ch_per[c]  <= per_d;
      end
    end
  end

  // read-back
  always_comb begin
    rdata = '0;
    if (aligned && in_range) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata[EN_BIT]            = ch_en[ch_idx];
          rdata[PRE_LSB +: PRE_W]  = ch_pre[ch_idx];
        end
        SEL_DUTY: rdata[CNT_W-1:0] = ch_duty[ch_idx];
        SEL_PER:  rdata[CNT_W-1:0] = ch_per[ch_idx];
        default:  if (ch_idx == CH_W'(MASTER_CH)) rdata[EN_BIT] = master_en;
      endcase
    end
  end

  // a write to the master address lands in the master bit
  assert_master_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_hit |=> (master_en == $past(wdata[EN_BIT])));

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int PRE_W = 14,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] cfg_per,
  output logic             pwm_o
);

  logic             live_q,     live_d;
  logic [PRE_W-1:0] pre_q,      pre_d;
  logic [CNT_W-1:0] per_q,      per_d;
  logic [PRE_W-1:0] act_pre_q,  act_pre_d;
  logic [CNT_W-1:0] act_duty_q, act_duty_d;
  logic [CNT_W-1:0] act_per_q,  act_per_d;

  logic             tick;
  logic [CNT_W:0]   per_inc;
  logic             wrap;
  logic             load;

  always_comb begin
    tick    = (pre_q == act_pre_q);
    per_inc = {1'b0, per_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap    = tick && (per_inc >= {1'b0, act_per_q});
    load    = run && (!live_q || wrap);
  end

  always_comb begin
    live_d     = live_q;
    pre_d      = pre_q;
    per_d      = per_q;
    act_pre_d  = act_pre_q;
    act_duty_d = act_duty_q;
    act_per_d  = act_per_q;
    if (!run) begin
      live_d = 1'b0;
      pre_d  = '0;
      per_d  = '0;
    end else if (!live_q) begin
      live_d = 1'b1;
      pre_d  = '0;
      per_d  = '0;
    end else if (tick) begin
      pre_d = '0;
      per_d = wrap ? '0 : per_inc[CNT_W-1:0];
    end else begin
      pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end
    if (load) begin
      act_pre_d  = cfg_pre;
      act_duty_d = cfg_duty;
      act_per_d  = cfg_per;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= 1'b0;
      pre_q      <= '0;
      per_q      <= '0;
      act_pre_q  <= '0;
      act_duty_q <= '0;
      act_per_q  <= '0;
    end else begin
      live_q     <= live_d;
      pre_q      <= pre_d;
      per_q      <= per_d;
      act_pre_q  <= act_pre_d;
      act_duty_q <= act_duty_d;
      act_per_q  <= act_per_d;
    end
  end

  assign pwm_o = run && live_q && (per_q < act_duty_q);

  // a stopped channel has cleared counters on the next edge
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!live_q && pre_q == '0 && per_q == '0));

  // counters stay inside the active period and prescale
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((per_q < act_per_q || per_q == '0) && pre_q <= act_pre_q));

  // full duty keeps the output high
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live_q && act_duty_q != '0 && act_duty_q >= act_per_q) |-> pwm_o);

  // running values change only at a period start
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && per_q != '0) |->
      (act_duty_q == $past(act_duty_q) && act_per_q == $past(act_per_q)
       && act_pre_q == $past(act_pre_q)));

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic                         rst_n_sync;
  logic                         master_en;
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0][PRE_W-1:0] ch_pre;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_duty;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_per;

  pwm_quad_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pwm_quad_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .master_en (master_en),
    .ch_en     (ch_en),
    .ch_pre    (ch_pre),
    .ch_duty   (ch_duty),
    .ch_per    (ch_per)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_quad_chan #(
      .PRE_W (PRE_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .run      (master_en && ch_en[c]),
      .cfg_pre  (ch_pre[c]),
      .cfg_duty (ch_duty[c]),
      .cfg_per  (ch_per[c]),
      .pwm_o    (pwm_out[c])
    );
  end

endmodule

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;

  logic        clk;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [5:0] A_MASTER = 6'h3C;

  pwm_quad dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [5:0] ra(input int ch, input int r);
    return 6'(ch * 16 + r * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic start_ch(input int ch, input int pre, input int pv, input int dc);
    bus_write(ra(ch, 1), 32'(dc));
    bus_write(ra(ch, 2), 32'(pv));
    bus_write(ra(ch, 0), 32'((pre << 2) | 1));
  endtask

  // call right after the write that starts the channel returns
  task automatic check_wave(input int ch, input int pre, input int pv, input int dc,
                            input int n, input string tag);
    int pv_e = (pv == 0) ? 1 : pv;
    int per  = (pre + 1) * pv_e;
    int hi   = (pre + 1) * ((dc < pv_e) ? dc : pv_e);
    int bad  = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== ((i % per) < hi)) bad++;
    end
    check(tag, 32'(bad), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 3; r++) begin
        bus_read(ra(c, r), d);
        check("R9 register reset value", d, 32'd0);
      end
    end
    bus_read(A_MASTER, d);
    check("R9 master reset value", d, 32'd0);
    check("R9 outputs low after reset", {28'd0, pwm_out}, 32'd0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    bus_write(ra(1, 1), 32'hFFFF_1234);
    bus_write(ra(1, 2), 32'h0000_ABCD);
    bus_write(ra(1, 0), 32'hFFFF_FFFE);
    bus_read(ra(1, 0), d);
    check("R1 control read-back masks to enable and prescale", d, 32'h0000_FFFC);
    bus_read(ra(1, 1), d);
    check("R1 duty read-back 16 bits", d, 32'h0000_1234);
    bus_read(ra(1, 2), d);
    check("R1 period read-back", d, 32'h0000_ABCD);
    bus_read(ra(1, 0), d);
    bus_write(ra(1, 0), d | 32'd1);
    bus_read(ra(1, 0), d);
    check("R1 read-modify-write keeps prescale", d, 32'h0000_FFFD);
    repeat (4) @(negedge clk);
    check("R2 enabled channel low while master clear", {31'd0, pwm_out[1]}, 32'd0);
    bus_write(ra(1, 0), 32'd0);
    bus_write(A_MASTER, 32'hFFFF_FFFF);
    bus_read(A_MASTER, d);
    check("R2 master read-back", d, 32'd1);
    bus_write(A_MASTER, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(6'h0C, 32'hFFFF_FFFF);
    bus_write(6'h2C, 32'hFFFF_FFFF);
    bus_write(6'h01, 32'hFFFF_FFFF);
    bus_write(6'h16, 32'hFFFF_FFFF);
    bus_read(6'h0C, d);
    check("R8 unmapped offset reads zero", d, 32'd0);
    bus_read(6'h01, d);
    check("R8 unaligned address reads zero", d, 32'd0);
    bus_read(ra(0, 0), d);
    check("R8 unaligned write left control unchanged", d, 32'd0);
    bus_read(ra(1, 1), d);
    check("R8 unaligned write left duty unchanged", d, 32'h0000_1234);
    bus_read(A_MASTER, d);
    check("R8 master untouched by unmapped writes", d, 32'd0);
  endtask

  task automatic t_basic;
    bus_write(A_MASTER, 32'd1);
    start_ch(0, 0, 8, 3);
    check_wave(0, 0, 8, 3, 24, "R4 R6 waveform pv=8 dc=3 no prescale");
  endtask

  task automatic t_prescale;
    start_ch(1, 2, 3, 1);
    check_wave(1, 2, 3, 1, 27, "R4 waveform with prescale 2");
  endtask

  task automatic t_full_zero;
    start_ch(2, 0, 4, 9);
    check_wave(2, 0, 4, 9, 12, "R5 duty above period stays high");
    bus_write(ra(2, 0), 32'd0);
    check("R3 disabled channel goes low", {31'd0, pwm_out[2]}, 32'd0);
    start_ch(3, 1, 4, 0);
    check_wave(3, 1, 4, 0, 16, "R5 zero duty stays low");
    bus_write(ra(3, 0), 32'd0);
  endtask

  task automatic t_shadow;
    int bad = 0;
    bus_write(ra(0, 0), 32'd0);
    bus_write(ra(0, 1), 32'd2);
    bus_write(ra(0, 2), 32'd8);
    bus_write(ra(0, 0), 32'd1);
    repeat (5) @(negedge clk);            // sample index 4
    bus_write(ra(0, 1), 32'd7);           // returns at index 6
    check("R6 mid-period duty write not applied", {31'd0, pwm_out[0]}, 32'd0);
    @(negedge clk);                       // index 7
    check("R6 old duty holds to period end", {31'd0, pwm_out[0]}, 32'd0);
    for (int i = 8; i < 16; i++) begin
      @(negedge clk);
      if (pwm_out[0] !== ((i - 8) < 7)) bad++;
    end
    check("R6 new duty applied from next period", 32'(bad), 32'd0);
  endtask

  task automatic t_master;
    int bad = 0;
    bus_write(A_MASTER, 32'd0);
    check("R2 master clear drops outputs", {28'd0, pwm_out}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwm_out !== 4'd0) bad++;
    end
    check("R2 outputs stay low while master clear", 32'(bad), 32'd0);
    bus_write(A_MASTER, 32'd1);
    check_wave(1, 2, 3, 1, 18, "R7 restart after master begins fresh period");
    bus_write(ra(1, 0), 32'd0);
    bus_write(ra(1, 0), 32'((2 << 2) | 1));
    check_wave(1, 2, 3, 1, 18, "R7 restart after channel disable");
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_unmapped();
    t_basic();
    t_prescale();
    t_full_zero();
    t_shadow();
    t_master();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule